// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a programmable two-level logic core. Fourteen dedicated input signals and twelve feedback signals (26 in all) enter the array. Each signal is offered in true and inverted form, so each product-term row has 52 literal columns. A stored connection bit decides whether a literal takes part in a row's AND. The rows are grouped into twelve sum outputs, and the groups have uneven sizes. Each sum output also owns one output-enable row. Two global rows are shared by all outputs: one is an asynchronous-reset term and the other is a synchronous-preset term. The registers, polarity selection and pin drivers that consume these terms sit outside this block.

The connection pattern is loaded one 52-bit row per write through a valid/ready port. It is read back through a request/response stream pair. A sticky security flag hides the pattern from readback and withdraws permission for register preload. A single-cycle full-erase strobe returns every connection to the unconnected state and clears the security flag. On the request channel a request is taken when `rd_req_valid_i` and `rd_req_ready_o` are both high. The request side is ready whenever the response slot is empty or is being drained in that cycle. A response that is not taken holds its data until `rd_rsp_ready_i` rises. On the write channel `cfg_wr_ready_o` is low only in a cycle where an erase is applied.

Top module: `sop_logic_array`

## Requirements
- R1: Signal s (0..13 = `ded_i[s]`, 14..25 = `fb_i[s-14]`) drives literal column 2s in true form and column 2s+1 inverted. A row is HIGH when every literal connected (bit = 1) in it is HIGH.
- R2: A row with no connected literal evaluates HIGH.
- R3: A row that connects both columns of any one signal is LOW whatever the inputs are.
- R4: Row 0 is the reset term and row 149 is the preset term. Output k owns a block that starts at base B_k with its enable row, followed by its sum rows. Sum output k is the OR of its sum rows. The term counts, in output order, are 8,8,10,12,14,16,16,14,12,10,8,8, so B = 1,10,19,30,43,58,75,92,107,120,131,140.
- R5: `oe_o[k]` is row B_k, so an all-zero row means always enabled and an all-ones row means always disabled. `ar_term_o` is row 0 and `sp_term_o` is row 149.
- R6: An accepted write stores `cfg_wr_data_i` in row `cfg_wr_row_i`, and the new row is seen on the outputs from the cycle after the accepting edge. A write to a row index of 150 or above changes nothing. A read of such an index returns zero.
- R7: While the security flag is set, every read response is zero and `preload_ok_o` is low. The logic outputs keep working.
- R8: Pulsing `sec_set_i` sets the flag. Only an erase or reset clears it. Writes and further pulses leave it set.
- R9: An `erase_i` cycle clears all rows and the flag at that edge, and any write in that cycle is dropped (`cfg_wr_ready_o` low). After the erase, every sum, enable and global term reads HIGH.
- R10: A read response appears one cycle after its request is accepted. It holds valid and data while `rd_rsp_ready_i` is low, and responses come back in request order.
- R11: After reset the array is in the erased state and `preload_ok_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ded_i | input | 14 | Dedicated array inputs |
| fb_i | input | 12 | Feedback array inputs |
| sum_o | output | 12 | Sum-of-products outputs |
| oe_o | output | 12 | Per-output enable terms |
| ar_term_o | output | 1 | Global asynchronous-reset term |
| sp_term_o | output | 1 | Global synchronous-preset term |
| preload_ok_o | output | 1 | High when register preload is permitted |
| cfg_wr_valid_i | input | 1 | Row write valid |
| cfg_wr_ready_o | output | 1 | Row write ready |
| cfg_wr_row_i | input | 8 | Row index to write |
| cfg_wr_data_i | input | 52 | Connection bits for the row |
| sec_set_i | input | 1 | Set security flag |
| erase_i | input | 1 | Full-erase strobe |
| rd_req_valid_i | input | 1 | Readback request valid |
| rd_req_ready_o | output | 1 | Readback request ready |
| rd_req_row_i | input | 8 | Row index to read |
| rd_rsp_valid_o | output | 1 | Readback response valid |
| rd_rsp_ready_i | input | 1 | Readback response ready |
| rd_rsp_data_o | output | 52 | Readback row data |

## Verification
The properties assume that reset is applied at start-up. They also assume that the consumer of the response stream eventually raises ready, and that the request row index is stable while a request is offered. The bench holds each request steady until it is taken. It toggles response ready in a pseudo-random pattern and then releases it. It changes inputs only away from the sampling edge, and it drives erase for exactly one cycle. No property depends on how the sum outputs settle, because the bench compares those outputs against its own model of the array.

// File: rtl/sop_pkg.sv
package sop_pkg;

  // Term count of sum output k: counts rise from the ends toward the middle
  function automatic int terms_of(int k, int n_out, int t_min, int t_step);
    int j;
    j = (k < n_out / 2) ? k : (n_out - 1 - k);
    return t_min + t_step * ((j == 0) ? 0 : (j - 1));
  endfunction

  // Row index of the enable row that opens output k's block
  function automatic int base_of(int k, int n_out, int t_min, int t_step);
    int b;
    b = 1;
    for (int j = 0; j < k; j++) b += terms_of(j, n_out, t_min, t_step) + 1;
    return b;
  endfunction

  // Reset row, all output blocks, then the preset row
  function automatic int rows_total(int n_out, int t_min, int t_step);
    return base_of(n_out, n_out, t_min, t_step) + 1;
  endfunction

endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
  parameter int NROW  = 150,
  parameter int NCOL  = 52,
  parameter int ROW_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           erase_i,
  input  logic                           wr_valid_i,
  input  logic [ROW_W-1:0]               wr_row_i,
  input  logic [NCOL-1:0]                wr_data_i,
  input  logic                           sec_set_i,
  output logic                           wr_ready_o,
  output logic [NROW-1:0][NCOL-1:0]      pat_o,
  output logic                           secure_o
);

  logic wr_hit;

  assign wr_ready_o = ~erase_i;
  assign wr_hit     = wr_valid_i && wr_ready_o && (wr_row_i < ROW_W'(NROW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_o    <= '0;
      secure_o <= 1'b0;
    end else if (erase_i) begin
      pat_o    <= '0;
      secure_o <= 1'b0;
    end else begin
      if (wr_hit) pat_o[wr_row_i] <= wr_data_i;
      if (sec_set_i) secure_o <= 1'b1;
    end
  end

endmodule

// File: rtl/sop_term_eval.sv
module sop_term_eval #(
  parameter int NROW = 150,
  parameter int NCOL = 52
) (
  input  logic [NROW-1:0][NCOL-1:0] pat_i,
  input  logic [NCOL-1:0]           lit_i,
  output logic [NROW-1:0]           pt_o
);

  // A connected literal must be high; an unconnected one is a don't-care
  for (genvar r = 0; r < NROW; r++) begin : g_row
    assign pt_o[r] = &(~pat_i[r] | lit_i);
  end

endmodule

// File: rtl/sop_sum_or.sv
module sop_sum_or #(
  parameter int NUM_OUT = 12,
  parameter int T_MIN   = 8,
  parameter int T_STEP  = 2,
  parameter int NROW    = 150
) (
  input  logic [NROW-1:0]    pt_i,
  output logic [NUM_OUT-1:0] sum_o,
  output logic [NUM_OUT-1:0] oe_o,
  output logic               ar_o,
  output logic               sp_o
);

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    localparam int BASE = sop_pkg::base_of(k, NUM_OUT, T_MIN, T_STEP);
    localparam int CNT  = sop_pkg::terms_of(k, NUM_OUT, T_MIN, T_STEP);
    assign oe_o[k]  = pt_i[BASE];
    assign sum_o[k] = |pt_i[BASE+1 +: CNT];
  end

  assign ar_o = pt_i[0];
  assign sp_o = pt_i[NROW-1];

endmodule

// File: rtl/sop_readback.sv
module sop_readback #(
  parameter int NROW  = 150,
  parameter int NCOL  = 52,
  parameter int ROW_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NROW-1:0][NCOL-1:0] pat_i,
  input  logic                      secure_i,
  input  logic                      req_valid_i,
  input  logic [ROW_W-1:0]          req_row_i,
  output logic                      req_ready_o,
  output logic                      rsp_valid_o,
  output logic [NCOL-1:0]           rsp_data_o,
  input  logic                      rsp_ready_i
);

  logic            take;
  logic            in_range;
  logic [NCOL-1:0] row_data;

  assign req_ready_o = !rsp_valid_o || rsp_ready_i;
  assign take        = req_valid_i && req_ready_o;
  assign in_range    = req_row_i < ROW_W'(NROW);

  always_comb begin
    row_data = '0;
    if (in_range && !secure_i) row_data = pat_i[req_row_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else if (take) begin
      rsp_valid_o <= 1'b1;
      rsp_data_o  <= row_data;
    end else if (rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end

endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array #(
  parameter int NUM_DED = 14,
  parameter int NUM_OUT = 12,
  parameter int T_MIN   = 8,
  parameter int T_STEP  = 2,
  localparam int NSIG   = NUM_DED + NUM_OUT,
  localparam int NCOL   = 2 * NSIG,
  localparam int NROW   = sop_pkg::rows_total(NUM_OUT, T_MIN, T_STEP),
  localparam int ROW_W  = $clog2(NROW + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DED-1:0] ded_i,
  input  logic [NUM_OUT-1:0] fb_i,
  output logic [NUM_OUT-1:0] sum_o,
  output logic [NUM_OUT-1:0] oe_o,
  output logic               ar_term_o,
  output logic               sp_term_o,
  output logic               preload_ok_o,
  input  logic               cfg_wr_valid_i,
  output logic               cfg_wr_ready_o,
  input  logic [ROW_W-1:0]   cfg_wr_row_i,
  input  logic [NCOL-1:0]    cfg_wr_data_i,
  input  logic               sec_set_i,
  input  logic               erase_i,
  input  logic               rd_req_valid_i,
  output logic               rd_req_ready_o,
  input  logic [ROW_W-1:0]   rd_req_row_i,
  output logic               rd_rsp_valid_o,
  input  logic               rd_rsp_ready_i,
  output logic [NCOL-1:0]    rd_rsp_data_o
);

  logic [NSIG-1:0]            sig;
  logic [NCOL-1:0]            lit;
  logic [NROW-1:0][NCOL-1:0]  pat;
  logic [NROW-1:0]            pt;
  logic                       secure;

  assign sig = {fb_i, ded_i};

  // Even column: true form, odd column: inverted form
  for (genvar s = 0; s < NSIG; s++) begin : g_lit
    assign lit[2*s]   = sig[s];
    assign lit[2*s+1] = ~sig[s];
  end

  sop_cfg_store #(.NROW(NROW), .NCOL(NCOL), .ROW_W(ROW_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .erase_i    (erase_i),
    .wr_valid_i (cfg_wr_valid_i),
    .wr_row_i   (cfg_wr_row_i),
    .wr_data_i  (cfg_wr_data_i),
    .sec_set_i  (sec_set_i),
    .wr_ready_o (cfg_wr_ready_o),
    .pat_o      (pat),
    .secure_o   (secure)
  );

  sop_term_eval #(.NROW(NROW), .NCOL(NCOL)) u_terms (
    .pat_i (pat),
    .lit_i (lit),
    .pt_o  (pt)
  );

  sop_sum_or #(.NUM_OUT(NUM_OUT), .T_MIN(T_MIN), .T_STEP(T_STEP), .NROW(NROW)) u_or (
    .pt_i  (pt),
    .sum_o (sum_o),
    .oe_o  (oe_o),
    .ar_o  (ar_term_o),
    .sp_o  (sp_term_o)
  );

  sop_readback #(.NROW(NROW), .NCOL(NCOL), .ROW_W(ROW_W)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .pat_i       (pat),
    .secure_i    (secure),
    .req_valid_i (rd_req_valid_i),
    .req_row_i   (rd_req_row_i),
    .req_ready_o (rd_req_ready_o),
    .rsp_valid_o (rd_rsp_valid_o),
    .rsp_data_o  (rd_rsp_data_o),
    .rsp_ready_i (rd_rsp_ready_i)
  );

  assign preload_ok_o = ~secure;

endmodule

// File: rtl/sop_logic_array_chk.sv
module sop_logic_array_chk #(
  parameter int NUM_OUT = 12,
  parameter int NCOL    = 52,
  parameter int NROW    = 150,
  parameter int ROW_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_OUT-1:0] sum_o,
  input logic [NUM_OUT-1:0] oe_o,
  input logic               ar_term_o,
  input logic               sp_term_o,
  input logic               preload_ok_o,
  input logic               erase_i,
  input logic               rd_req_valid_i,
  input logic               rd_req_ready_o,
  input logic [ROW_W-1:0]   rd_req_row_i,
  input logic               rd_rsp_valid_o,
  input logic               rd_rsp_ready_i,
  input logic [NCOL-1:0]    rd_rsp_data_o
);

  AST_SEC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!preload_ok_o && !erase_i) |=> !preload_ok_o); // R8

  AST_ERASE_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    erase_i |=> (&sum_o && &oe_o && ar_term_o && sp_term_o && preload_ok_o)); // R9

  AST_SECURE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid_i && rd_req_ready_o && !preload_ok_o)
      |=> (rd_rsp_valid_o && rd_rsp_data_o == '0)); // R7

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid_i && rd_req_ready_o && rd_req_row_i >= ROW_W'(NROW))
      |=> (rd_rsp_valid_o && rd_rsp_data_o == '0)); // R6

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rsp_valid_o && !rd_rsp_ready_i) |=> (rd_rsp_valid_o && $stable(rd_rsp_data_o))); // R10

endmodule

bind sop_logic_array sop_logic_array_chk #(
  .NUM_OUT(NUM_OUT), .NCOL(NCOL), .NROW(NROW), .ROW_W(ROW_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .sum_o          (sum_o),
  .oe_o           (oe_o),
  .ar_term_o      (ar_term_o),
  .sp_term_o      (sp_term_o),
  .preload_ok_o   (preload_ok_o),
  .erase_i        (erase_i),
  .rd_req_valid_i (rd_req_valid_i),
  .rd_req_ready_o (rd_req_ready_o),
  .rd_req_row_i   (rd_req_row_i),
  .rd_rsp_valid_o (rd_rsp_valid_o),
  .rd_rsp_ready_i (rd_rsp_ready_i),
  .rd_rsp_data_o  (rd_rsp_data_o)
);

// File: tb/sop_logic_array_tb_top.sv
`timescale 1ns/1ps
module sop_logic_array_tb_top;

  localparam int NROW = 150;
  localparam int NCOL = 52;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] ded_i = '0;
  logic [11:0] fb_i = '0;
  logic [11:0] sum_o, oe_o;
  logic        ar_term_o, sp_term_o, preload_ok_o;
  logic        cfg_wr_valid_i = 1'b0;
  logic        cfg_wr_ready_o;
  logic [7:0]  cfg_wr_row_i = '0;
  logic [51:0] cfg_wr_data_i = '0;
  logic        sec_set_i = 1'b0;
  logic        erase_i = 1'b0;
  logic        rd_req_valid_i = 1'b0;
  logic        rd_req_ready_o;
  logic [7:0]  rd_req_row_i = '0;
  logic        rd_rsp_valid_o;
  logic        rd_rsp_ready_i = 1'b1;
  logic [51:0] rd_rsp_data_o;

  always #5 clk = ~clk;

  sop_logic_array dut_i (
    .clk(clk), .rst_n(rst_n), .ded_i(ded_i), .fb_i(fb_i),
    .sum_o(sum_o), .oe_o(oe_o), .ar_term_o(ar_term_o), .sp_term_o(sp_term_o),
    .preload_ok_o(preload_ok_o),
    .cfg_wr_valid_i(cfg_wr_valid_i), .cfg_wr_ready_o(cfg_wr_ready_o),
    .cfg_wr_row_i(cfg_wr_row_i), .cfg_wr_data_i(cfg_wr_data_i),
    .sec_set_i(sec_set_i), .erase_i(erase_i),
    .rd_req_valid_i(rd_req_valid_i), .rd_req_ready_o(rd_req_ready_o),
    .rd_req_row_i(rd_req_row_i), .rd_rsp_valid_o(rd_rsp_valid_o),
    .rd_rsp_ready_i(rd_rsp_ready_i), .rd_rsp_data_o(rd_rsp_data_o)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit bp_en = 0;

  // Independent model of the array contents and the row map
  bit [51:0] mdl [NROW];
  bit        msec = 0;
  int        cnt [12] = '{8, 8, 10, 12, 14, 16, 16, 14, 12, 10, 8, 8};
  int        base [12];

  logic [51:0] exp_q [$];

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit term(int r, bit [25:0] sig);
    for (int c = 0; c < NCOL; c++) begin
      if (mdl[r][c]) begin
        if ((c % 2 == 0) ? !sig[c/2] : sig[c/2]) return 1'b0;
      end
    end
    return 1'b1;
  endfunction

  function automatic bit [25:0] expect_outs(bit [13:0] d, bit [11:0] f);
    bit [25:0] sig;
    bit [11:0] s, e;
    sig = {f, d};
    for (int k = 0; k < 12; k++) begin
      e[k] = term(base[k], sig);
      s[k] = 1'b0;
      for (int t = 1; t <= cnt[k]; t++) s[k] |= term(base[k] + t, sig);
    end
    return {s, e, term(0, sig), term(NROW - 1, sig)};
  endfunction

  task automatic check_outs(string req);
    bit [25:0] exp;
    logic [25:0] act;
    @(negedge clk);
    exp = expect_outs(ded_i, fb_i);
    act = {sum_o, oe_o, ar_term_o, sp_term_o};
    chk(act === exp, req, 64'(act), 64'(exp));
  endtask

  task automatic wr_row(int r, bit [51:0] d);
    @(posedge clk); #1;
    cfg_wr_valid_i = 1'b1; cfg_wr_row_i = 8'(r); cfg_wr_data_i = d;
    @(posedge clk); #1;
    cfg_wr_valid_i = 1'b0;
    if (r < NROW) mdl[r] = d;
  endtask

  // Driver: pushes the expected response when its request is taken
  task automatic rd_push(int r);
    @(posedge clk); #1;
    rd_req_valid_i = 1'b1; rd_req_row_i = 8'(r);
    forever begin
      @(negedge clk);
      if (rd_req_ready_o) begin
        exp_q.push_back((msec || r >= NROW) ? 52'h0 : mdl[r]);
        break;
      end
    end
    @(posedge clk); #1;
    rd_req_valid_i = 1'b0;
  endtask

  // Monitor: compares each response as it is consumed (R10 order and data)
  always @(negedge clk) begin
    if (rst_n && rd_rsp_valid_o && rd_rsp_ready_i) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected response", 64'(rd_rsp_data_o), 64'h0);
      end else begin
        logic [51:0] e;
        e = exp_q.pop_front();
        chk(rd_rsp_data_o === e, "R10/R6/R7 readback", 64'(rd_rsp_data_o), 64'(e));
      end
    end
  end

  // Back-pressure on the response channel
  always @(posedge clk) begin
    #1;
    rd_rsp_ready_i = bp_en ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 64'h0, 64'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int b;
    b = 1;
    for (int k = 0; k < 12; k++) begin
      base[k] = b;
      b += cnt[k] + 1;
    end
    for (int r = 0; r < NROW; r++) mdl[r] = '0;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11: erased state after reset
    @(negedge clk);
    chk({sum_o, oe_o, ar_term_o, sp_term_o} === 26'h3FF_FFFF, "R11 outputs after reset",
        64'({sum_o, oe_o, ar_term_o, sp_term_o}), 64'h3FF_FFFF);
    chk(preload_ok_o === 1'b1, "R11 preload_ok after reset", 64'(preload_ok_o), 64'h1);
    // R2: empty rows are high for any input
    ded_i = 14'h2A5C; fb_i = 12'h9C3;
    check_outs("R2 empty rows high");

    // R3: every sum row contradictory, so every sum is low
    for (int k = 0; k < 12; k++)
      for (int t = 1; t <= cnt[k]; t++) wr_row(base[k] + t, 52'h3);
    wr_row(base[2], {52{1'b1}});   // R5: enable always off
    wr_row(0, 52'(1) << 10);       // R5: reset term = ded5 true
    wr_row(NROW - 1, 52'(1) << 29); // R5: preset term = fb0 inverted
    for (int i = 0; i < 4; i++) begin
      ded_i = 14'($urandom); fb_i = 12'($urandom);
      check_outs("R3 contradictory rows low");
    end
    ded_i = 14'h0020; fb_i = 12'h000;
    check_outs("R5 enable/global terms");
    chk(oe_o[2] === 1'b0 && ar_term_o === 1'b1 && sp_term_o === 1'b1, "R5 oe2 off, ar/sp on",
        64'({oe_o[2], ar_term_o, sp_term_o}), 64'h3);

    // R1/R4: a few real product terms
    wr_row(base[0] + 1, (52'(1) << 0) | (52'(1) << 35));
    wr_row(base[5] + 3, (52'(1) << 40) | (52'(1) << 7));
    wr_row(base[11] + cnt[11], (52'(1) << 26) | (52'(1) << 50));
    wr_row(base[6] + 1, 52'h0); // R2: sum6 constant high
    ded_i = 14'h0001; fb_i = 12'h000;
    check_outs("R1 sum0 = ded0 & ~fb3");
    chk(sum_o[0] === 1'b1 && sum_o[6] === 1'b1, "R1/R2 sum0 and sum6 high",
        64'({sum_o[0], sum_o[6]}), 64'h3);
    for (int i = 0; i < 30; i++) begin
      ded_i = 14'($urandom); fb_i = 12'($urandom);
      check_outs("R1/R4 random vector");
    end

    // R6: out-of-range writes change nothing
    wr_row(150, {52{1'b1}});
    wr_row(255, {52{1'b1}});
    for (int i = 0; i < 4; i++) begin
      ded_i = 14'($urandom); fb_i = 12'($urandom);
      check_outs("R6 out-of-range write ignored");
    end

    // R10/R6: reads under back-pressure
    bp_en = 1;
    rd_push(base[0] + 1);
    rd_push(base[5] + 3);
    rd_push(base[11] + cnt[11]);
    rd_push(base[2]);
    rd_push(NROW - 1);
    rd_push(200);
    rd_push(150);
    rd_push(0);
    bp_en = 0;
    repeat (6) @(posedge clk);

    // R7: security hides the pattern and blocks preload
    @(posedge clk); #1 sec_set_i = 1'b1;
    @(posedge clk); #1 sec_set_i = 1'b0;
    msec = 1;
    @(negedge clk);
    chk(preload_ok_o === 1'b0, "R7 preload blocked", 64'(preload_ok_o), 64'h0);
    rd_push(base[0] + 1);
    rd_push(base[2]);
    ded_i = 14'h0001; fb_i = 12'h000;
    check_outs("R7 logic still active while secure");

    // R8: flag stays set through writes and further pulses
    wr_row(base[7] + 2, 52'h0);
    @(posedge clk); #1 sec_set_i = 1'b1;
    @(posedge clk); #1 sec_set_i = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(preload_ok_o === 1'b0, "R8 security sticky", 64'(preload_ok_o), 64'h0);
    check_outs("R8 write while secure applied");

    // R9: single-cycle erase, write in the same cycle dropped
    @(posedge clk); #1;
    erase_i = 1'b1;
    cfg_wr_valid_i = 1'b1; cfg_wr_row_i = 8'd1; cfg_wr_data_i = 52'h3;
    @(negedge clk);
    chk(cfg_wr_ready_o === 1'b0, "R9 write not ready during erase", 64'(cfg_wr_ready_o), 64'h0);
    @(posedge clk); #1;
    erase_i = 1'b0; cfg_wr_valid_i = 1'b0;
    for (int r = 0; r < NROW; r++) mdl[r] = '0;
    msec = 0;
    @(negedge clk);
    chk({sum_o, oe_o, ar_term_o, sp_term_o} === 26'h3FF_FFFF, "R9 all terms high after erase",
        64'({sum_o, oe_o, ar_term_o, sp_term_o}), 64'h3FF_FFFF);
    chk(preload_ok_o === 1'b1, "R9 security cleared", 64'(preload_ok_o), 64'h1);
    rd_push(1);
    rd_push(base[7] + 2);
    repeat (6) @(posedge clk);

    chk(exp_q.size() == 0, "R10 all responses returned", 64'(exp_q.size()), 64'h0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule